// File: doc/BRIEF.md
# Address-match breakpoint comparator

This block watches every reference that the paging logic sees and compares it against a breakpoint address held in an internal register. The register also holds a mode bit and a two-bit condition code. When a reference matches, the block raises a memory-protect flag and a breakpoint status bit. It also requests trap mode, so that the interrupt is taken before the next instruction begins. A match never aborts the instruction in flight and never signals a fault.

Software loads the breakpoint register through a single write strobe. The processor then presents one reference per cycle, with its address, its mode, its kind, and qualifiers for fast-memory and execute-type accesses. The processor acknowledges the outputs with three strobes: an instruction-boundary pulse ends the trap request, a protect-clear pulse drops the memory-protect flag, and a status-clear pulse drops the breakpoint status bit.

Top module: `addr_watch`

## Requirements
- R1: After reset, `mem_prot`, `bp_status` and `trap_req` are 0, and the breakpoint register holds address 0, mode EXEC and condition 00.
- R2: With condition code 00 in `cfg_cond`, no reference ever matches.
- R3: With condition 01, only instruction fetches match (`ref_kind` = 01). A fetch made by an execute-type instruction (`ref_exec_fetch` = 1) does not match, and neither does a read (00) or a write (10).
- R4: With condition 10, only writes match (`ref_kind` = 10). Fetches do not match.
- R5: With condition 11, any kind of reference matches.
- R6: A match needs all 18 address bits equal to the stored address. It also needs the reference's effective mode to equal the stored mode bit, where 1 means USER and 0 means EXEC.
- R7: A reference flagged by `ref_fast` as going to fast memory through an accumulator or index field is never compared.
- R8: A reference with `ref_reloc_user` = 1 (made on behalf of an execute-relocated instruction) is compared as a USER reference, whatever the value of `ref_user`.
- R9: A match in cycle n sets `mem_prot`, `bp_status` and `trap_req` to 1 from the clock edge that ends cycle n.
- R10: `bp_status` stays 1 until a `stat_clr` pulse. If a match and `stat_clr` occur in the same cycle, the set wins.
- R11: `trap_req` is cleared by `insn_boundary`, and `mem_prot` is cleared by `prot_clr`. Each clear leaves the other outputs unchanged. A match in the same cycle as either clear wins over that clear.
- R12: A cycle with `ref_valid` = 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the breakpoint register |
| cfg_addr | input | 18 | Breakpoint address to load |
| cfg_user | input | 1 | Mode to load: 1 USER, 0 EXEC |
| cfg_cond | input | 2 | Condition code to load |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr | input | 18 | Reference address |
| ref_user | input | 1 | Reference mode: 1 USER, 0 EXEC |
| ref_reloc_user | input | 1 | Reference mapped as USER for an execute-relocated instruction |
| ref_kind | input | 2 | 00 read, 01 instruction fetch, 10 write |
| ref_fast | input | 1 | Fast-memory reference through an accumulator or index field |
| ref_exec_fetch | input | 1 | Fetch performed by an execute-type instruction |
| insn_boundary | input | 1 | Next instruction boundary reached; clears the trap request |
| prot_clr | input | 1 | Clears the memory-protect flag |
| stat_clr | input | 1 | Clears the breakpoint status bit |
| mem_prot | output | 1 | Memory-protect flag |
| bp_status | output | 1 | Breakpoint status bit |
| trap_req | output | 1 | Trap-mode request for the next instruction boundary |

## Verification
A wrong stored condition or mode shows up at the first qualifying reference: all three outputs either rise when they should stay low, or stay low when they should rise, one edge after that reference. A wrong sticky state shows up as early as the next idle cycle or the next clear strobe. For example, a status bit that decays by itself, or a clear that drops the wrong output, is visible immediately. Each kind and mode combination is therefore driven against each condition code, and every cycle's outputs are compared with a model.

// File: rtl/addr_watch.sv
module addr_watch #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cfg_user,
  input  logic [1:0]    cfg_cond,
  input  logic          ref_valid,
  input  logic [AW-1:0] ref_addr,
  input  logic          ref_user,
  input  logic          ref_reloc_user,
  input  logic [1:0]    ref_kind,
  input  logic          ref_fast,
  input  logic          ref_exec_fetch,
  input  logic          insn_boundary,
  input  logic          prot_clr,
  input  logic          stat_clr,
  output logic          mem_prot,
  output logic          bp_status,
  output logic          trap_req
);
  localparam logic [1:0] K_FETCH = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;

  logic [AW-1:0] wp_addr;
  logic          wp_user;
  logic [1:0]    wp_cond;
  logic          kind_ok, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_addr <= '0;
      wp_user <= 1'b0;
      wp_cond <= 2'b00;
    end else if (cfg_we) begin
      wp_addr <= cfg_addr;
      wp_user <= cfg_user;
      wp_cond <= cfg_cond;
    end
  end

  always_comb begin
    case (wp_cond)
      2'b01:   kind_ok = (ref_kind == K_FETCH) && !ref_exec_fetch;
      2'b10:   kind_ok = (ref_kind == K_WRITE);
      2'b11:   kind_ok = 1'b1;
      default: kind_ok = 1'b0;
    endcase
  end

  assign hit = ref_valid && !ref_fast && kind_ok &&
               (ref_addr == wp_addr) &&
               ((ref_user | ref_reloc_user) == wp_user);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_prot  <= 1'b0;
      bp_status <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      mem_prot  <= hit | (mem_prot  & ~prot_clr);
      bp_status <= hit | (bp_status & ~stat_clr);
      trap_req  <= hit | (trap_req  & ~insn_boundary);
    end
  end

  a_r9_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (mem_prot && bp_status && trap_req));

  a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_status && !stat_clr) |=> bp_status);

  a_r7_fast_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fast && !bp_status && !stat_clr) |=> !$rose(bp_status));

  a_r12_idle_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_valid && !trap_req) |=> !trap_req);

  a_r11_boundary_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_boundary && !hit) |=> !trap_req);

  a_r2_never: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_cond == 2'b00) |-> !hit);
endmodule

// File: tb/addr_watch_tb.sv
module addr_watch_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, cfg_user = 0;
  logic [17:0] cfg_addr = 0;
  logic [1:0] cfg_cond = 0;
  logic ref_valid = 0, ref_user = 0, ref_reloc_user = 0, ref_fast = 0, ref_exec_fetch = 0;
  logic [17:0] ref_addr = 0;
  logic [1:0] ref_kind = 0;
  logic insn_boundary = 0, prot_clr = 0, stat_clr = 0;
  logic mem_prot, bp_status, trap_req;

  always #2 clk = ~clk;

  addr_watch u_dut (.*);

  typedef struct {
    logic p, s, t;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic [17:0] m_addr = 0;
  logic m_user = 0;
  logic [1:0] m_cond = 0;
  logic m_p = 0, m_s = 0, m_t = 0;

  localparam logic [17:0] A = 18'h2A5C3;

  task automatic step(input logic we, input logic [17:0] ca, input logic cu, input logic [1:0] cc,
                      input logic v, input logic [17:0] a, input logic u, input logic rl,
                      input logic [1:0] k, input logic f, input logic xf,
                      input logic bnd, input logic pc, input logic sc, input string tag);
    logic h, kok;
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_addr = ca; cfg_user = cu; cfg_cond = cc;
    ref_valid = v; ref_addr = a; ref_user = u; ref_reloc_user = rl; ref_kind = k;
    ref_fast = f; ref_exec_fetch = xf; insn_boundary = bnd; prot_clr = pc; stat_clr = sc;
    kok = (m_cond == 2'b11) || (m_cond == 2'b10 && k == 2'b10) ||
          (m_cond == 2'b01 && k == 2'b01 && !xf);
    h = v && !f && kok && (a == m_addr) && ((u || rl) == m_user);
    m_p = h || (m_p && !pc);
    m_s = h || (m_s && !sc);
    m_t = h || (m_t && !bnd);
    if (we) begin m_addr = ca; m_user = cu; m_cond = cc; end
    e.p = m_p; e.s = m_s; e.t = m_t; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cfg(input logic [17:0] ca, input logic cu, input logic [1:0] cc, input string tag);
    step(1, ca, cu, cc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rf(input logic [17:0] a, input logic u, input logic rl, input logic [1:0] k,
                    input logic f, input logic xf, input string tag);
    step(0, 0, 0, 0, 1, a, u, rl, k, f, xf, 0, 0, 0, tag);
  endtask

  task automatic clr_all(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({mem_prot, bp_status, trap_req} !== {e.p, e.s, e.t}) begin
        fails++;
        $display("FAIL %s: got prot/stat/trap=%b%b%b expected %b%b%b",
                 e.tag, mem_prot, bp_status, trap_req, e.p, e.s, e.t);
      end
    end
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({mem_prot, bp_status, trap_req} !== 3'b000) begin
      fails++;
      $display("FAIL R1: got %b%b%b expected 000", mem_prot, bp_status, trap_req);
    end
    rst_n = 1;
    rf(0, 0, 0, 2'b00, 0, 0, "R1 reset cond never");
    cfg(A, 1, 2'b11, "R5 load");
    rf(A, 1, 0, 2'b00, 0, 0, "R5 R9 read hit");
    clr_all("R11 clear all");
    rf(A, 0, 0, 2'b00, 0, 0, "R6 mode mismatch");
    rf(A ^ 18'h20000, 1, 0, 2'b00, 0, 0, "R6 msb mismatch");
    rf(A ^ 18'h1, 1, 0, 2'b10, 0, 0, "R6 lsb mismatch");
    rf(A, 1, 0, 2'b10, 1, 0, "R7 fast ignored");
    rf(A, 0, 1, 2'b01, 0, 0, "R8 reloc as user");
    clr_all("R11 clear");
    step(0, 0, 0, 0, 0, A, 1, 0, 2'b00, 0, 0, 0, 0, 0, "R12 invalid");
    cfg(A, 1, 2'b00, "R2 load");
    rf(A, 1, 0, 2'b01, 0, 0, "R2 fetch");
    rf(A, 1, 0, 2'b10, 0, 0, "R2 write");
    cfg(A, 1, 2'b01, "R3 load");
    rf(A, 1, 0, 2'b10, 0, 0, "R3 write no");
    rf(A, 1, 0, 2'b01, 0, 1, "R3 exec fetch no");
    rf(A, 1, 0, 2'b00, 0, 0, "R3 read no");
    rf(A, 1, 0, 2'b01, 0, 0, "R3 fetch hit");
    clr_all("R11 clear");
    cfg(A, 1, 2'b10, "R4 load");
    rf(A, 1, 0, 2'b01, 0, 0, "R4 fetch no");
    rf(A, 1, 0, 2'b10, 0, 0, "R4 R9 write hit");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R11 boundary only");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R11 prot clear only");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 hold");
    step(0, 0, 0, 0, 1, A, 1, 0, 2'b10, 0, 0, 1, 1, 1, "R10 R11 set wins");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 stat clear");
    clr_all("R11 clear");
    cfg(A, 0, 2'b11, "R6 exec load");
    rf(A, 0, 0, 2'b10, 0, 0, "R6 exec hit");
    clr_all("R11 clear");
    rf(A, 0, 1, 2'b10, 0, 0, "R8 reloc not exec");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule